// File: doc/BRIEF.md
# Per-pin programmable blink generator

This block drives up to twenty general-purpose outputs with independent square-wave blink patterns. Every pin owns a slot holding a period, a high-time threshold and a phase counter. A shared tick strobe (nominally one every 10 ms, so periods are in hundredths of a second) advances every active slot by one step. The counter of an active slot wraps to zero on reaching the period, and the pin is high while the counter is below the threshold.

Software-side logic issues two kinds of command. A configuration command carries a pin mask, a period in ticks and a duty cycle in percent. It loads the same settings into every masked slot and restarts their phase. A stop command empties the masked slots and drives those pins low. The high-time threshold, period × duty / 100 with integer division, is computed once when the command is accepted, so the per-tick path only compares. A configuration is refused as a whole, with a one-cycle error pulse, if any masked pin is not currently configured as an output.

The block produces a blink data vector and an ownership vector. A pin's ownership bit is 1 while its slot is active, so a downstream multiplexer can choose between the blink data and the static data for that pin. Generating the tick and driving the pads are done elsewhere.

Top module: `blink_bank`

## Requirements
- R1: After a synchronous active-low reset, `blink_data`, `blink_own` and `cfg_err` are all 0.
- R2: An accepted configuration with a nonzero period loads every pin set in `cfg_mask`. In the next cycle those pins have `blink_own` = 1 and `blink_data` = 0, and their phase counter restarts at 0.
- R3: A tick advances each active pin's counter by one, and the counter wraps to 0 when it reaches the period. In cycles without a tick, `blink_data` and `blink_own` keep their values.
- R4: After each tick, an active pin's data bit is 1 exactly when its new counter value is below period × duty / 100, using integer division. Over one full period the pin is therefore high for that many ticks.
- R5: A duty value above 100 is treated as 100, which makes the pin high on every tick.
- R6: An accepted configuration with period 0 acts as a stop for the masked pins.
- R7: A stop command clears the slots of the pins set in `stop_mask`. In the next cycle their data and ownership bits are 0. Pins outside the mask are unaffected.
- R8: A configuration whose mask includes any pin with `pin_is_out` = 0 is refused. `cfg_err` is 1 for exactly the following cycle, and no slot changes.
- R9: When a stop and a configuration arrive in the same cycle, a pin set in both masks ends up stopped. Pins set in only one mask follow that command.
- R10: Each pin keeps its own period and threshold, so pins configured by different commands blink independently.
- R11: A configuration arriving in the same cycle as a tick takes precedence for the masked pins: their counter and data are 0 afterwards. Unmasked pins still advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle blink time-base strobe |
| pin_is_out | input | 20 | 1 for each pin currently configured as an output |
| cfg_valid | input | 1 | Configuration command strobe |
| cfg_mask | input | 20 | Pins affected by the configuration |
| cfg_period | input | 12 | Period in ticks; 0 means stop |
| cfg_duty | input | 7 | High fraction of the period, in percent |
| stop_valid | input | 1 | Stop command strobe |
| stop_mask | input | 20 | Pins to stop |
| blink_data | output | 20 | Blink level per pin |
| blink_own | output | 20 | 1 where the pin's slot is active |
| cfg_err | output | 1 | One-cycle pulse after a refused configuration |

## Verification
The assertions assume that `tick` and the command strobes are sampled as single-cycle pulses. They also assume that `pin_is_out` is stable around a command, because refusal is judged against its value in the command cycle. The bench drives every input on the falling clock edge and holds it for exactly one cycle. It keeps `pin_is_out` constant except in the refusal test, where one bit is cleared before the command is issued. The bench compares the outputs against a reference model of the slots, which covers duty values of 0, 100 and above 100, periods of 1, and commands that collide with ticks and with each other.

// File: rtl/blink_pkg.sv
// Shared definitions for the blink generator.
// Assumes: duty values are percentages, with 100 meaning always high.
package blink_pkg;

    // Full-scale duty value; larger requests are clamped to it.
    localparam int unsigned DUTY_FULL = 100;

    // Per-slot operation chosen by the command decoder for one cycle.
    typedef enum logic [1:0] {
        SLOT_HOLD  = 2'd0,
        SLOT_LOAD  = 2'd1,
        SLOT_CLEAR = 2'd2
    } slot_op_e;

endpackage

// File: rtl/blink_cmd_decode.sv
// Command decoder for the blink generator.
// Validates a configuration against the output-enable vector, turns the
// stop and configuration masks into one operation per slot (stop wins on
// overlap), and computes the shared high-time threshold once per command.
// Assumes: command strobes last one cycle; pin_is_out is valid in that cycle.
module blink_cmd_decode
    import blink_pkg::*;
#(
    parameter int NUM_PINS = 20,
    parameter int PERIOD_W = 12,
    parameter int DUTY_W   = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_PINS-1:0]             pin_is_out,
    input  logic                            cfg_valid,
    input  logic [NUM_PINS-1:0]             cfg_mask,
    input  logic [PERIOD_W-1:0]             cfg_period,
    input  logic [DUTY_W-1:0]               cfg_duty,
    input  logic                            stop_valid,
    input  logic [NUM_PINS-1:0]             stop_mask,
    output slot_op_e [NUM_PINS-1:0]         slot_op,
    output logic [PERIOD_W-1:0]             load_thresh,
    output logic                            cfg_err
);
    localparam int PROD_W = PERIOD_W + DUTY_W;

    logic                refused;
    logic                accepted;
    logic                cfg_is_stop;
    logic [DUTY_W-1:0]   duty_clamped;
    logic [PROD_W-1:0]   product;
    logic [NUM_PINS-1:0] clear_vec;
    logic [NUM_PINS-1:0] load_vec;

    // Judge the configuration and sort masks into load and clear sets.
    always_comb begin
        refused      = cfg_valid && ((cfg_mask & ~pin_is_out) != '0);
        accepted     = cfg_valid && !refused;
        cfg_is_stop  = accepted && (cfg_period == '0);
        clear_vec    = (stop_valid ? stop_mask : '0) | (cfg_is_stop ? cfg_mask : '0);
        load_vec     = (accepted && !cfg_is_stop) ? (cfg_mask & ~clear_vec) : '0;
    end

    // Clamp duty to full scale and derive the threshold with one divider.
    always_comb begin
        duty_clamped = (32'(cfg_duty) > DUTY_FULL) ? DUTY_W'(DUTY_FULL) : cfg_duty;
        product      = PROD_W'(cfg_period) * PROD_W'(duty_clamped);
        load_thresh  = PERIOD_W'(product / PROD_W'(DUTY_FULL));
    end

    // One operation code per slot.
    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_op
            assign slot_op[p] = clear_vec[p] ? SLOT_CLEAR :
                                load_vec[p]  ? SLOT_LOAD  : SLOT_HOLD;
        end
    endgenerate

    // Register the refusal as a one-cycle error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= refused;
    end

    AST_THRESH_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (load_thresh <= cfg_period)); // R5
    AST_NO_LOAD_AND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        stop_valid |-> ((load_vec & stop_mask) == '0)); // R9

endmodule

// File: rtl/blink_slot.sv
// One pin's blink slot: period, threshold, phase counter and level.
// A load restarts the phase with data low; a clear empties the slot; a
// tick advances an active slot and recomputes the level from the new count.
// Assumes: load_thresh never exceeds load_period (guaranteed by decoder).
module blink_slot
    import blink_pkg::*;
#(
    parameter int PERIOD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  slot_op_e            op,
    input  logic [PERIOD_W-1:0] load_period,
    input  logic [PERIOD_W-1:0] load_thresh,
    output logic                data,
    output logic                active
);
    logic [PERIOD_W-1:0] period_q;
    logic [PERIOD_W-1:0] thresh_q;
    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W:0]   cnt_inc;
    logic [PERIOD_W-1:0] cnt_next;

    // Next phase value with wrap at the period.
    always_comb begin
        cnt_inc  = {1'b0, cnt_q} + 1'b1;
        cnt_next = (cnt_inc >= {1'b0, period_q}) ? '0 : cnt_inc[PERIOD_W-1:0];
    end

    // Slot state update: clear, load, or advance on tick.
    always_ff @(posedge clk) begin
        if (!rst_n || op == SLOT_CLEAR) begin
            period_q <= '0;
            thresh_q <= '0;
            cnt_q    <= '0;
            data     <= 1'b0;
        end else if (op == SLOT_LOAD) begin
            period_q <= load_period;
            thresh_q <= load_thresh;
            cnt_q    <= '0;
            data     <= 1'b0;
        end else if (tick && period_q != '0) begin
            cnt_q    <= cnt_next;
            data     <= (cnt_next < thresh_q);
        end
    end

    assign active = (period_q != '0);

    AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q < period_q)); // R3
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!data && cnt_q == '0)); // R7
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && op == SLOT_HOLD) |=> ($stable(cnt_q) && $stable(data))); // R3
    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SLOT_LOAD) |=> (cnt_q == '0 && !data && active)); // R11
    AST_LEVEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && op == SLOT_HOLD && active) |=> (data == (cnt_q < thresh_q))); // R4

endmodule

// File: rtl/blink_bank.sv
// Bank of per-pin blink generators sharing one tick and one command path.
// Outputs a blink level and an ownership bit for each pin; ownership is 1
// while the pin's slot holds a nonzero period.
// Assumes: tick and command strobes are single-cycle pulses.
module blink_bank
    import blink_pkg::*;
#(
    parameter int NUM_PINS = 20,
    parameter int PERIOD_W = 12,
    parameter int DUTY_W   = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [NUM_PINS-1:0] pin_is_out,
    input  logic                cfg_valid,
    input  logic [NUM_PINS-1:0] cfg_mask,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic [DUTY_W-1:0]   cfg_duty,
    input  logic                stop_valid,
    input  logic [NUM_PINS-1:0] stop_mask,
    output logic [NUM_PINS-1:0] blink_data,
    output logic [NUM_PINS-1:0] blink_own,
    output logic                cfg_err
);
    slot_op_e [NUM_PINS-1:0] slot_op;
    logic [PERIOD_W-1:0]     load_thresh;

    blink_cmd_decode #(
        .NUM_PINS (NUM_PINS),
        .PERIOD_W (PERIOD_W),
        .DUTY_W   (DUTY_W)
    ) i_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_is_out  (pin_is_out),
        .cfg_valid   (cfg_valid),
        .cfg_mask    (cfg_mask),
        .cfg_period  (cfg_period),
        .cfg_duty    (cfg_duty),
        .stop_valid  (stop_valid),
        .stop_mask   (stop_mask),
        .slot_op     (slot_op),
        .load_thresh (load_thresh),
        .cfg_err     (cfg_err)
    );

    // One slot per pin.
    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_slot
            blink_slot #(
                .PERIOD_W (PERIOD_W)
            ) i_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .tick        (tick),
                .op          (slot_op[p]),
                .load_period (cfg_period),
                .load_thresh (load_thresh),
                .data        (blink_data[p]),
                .active      (blink_own[p])
            );
        end
    endgenerate

    AST_ERR_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cfg_valid)); // R8
    AST_REFUSED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !$past(stop_valid)) |-> $stable(blink_own)); // R8
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_valid |=> ((blink_own & $past(stop_mask)) == '0)); // R9
    AST_DATA_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_data & ~blink_own) == '0); // R7

endmodule

// File: tb/test_blink_bank.sv
// Self-checking bench for blink_bank: a table of period/duty rows with
// hand-computed high counts, then directed tests against a slot model.
module test_blink_bank;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 20;
    localparam int PW = 12;
    localparam int DW = 7;
    localparam logic [N-1:0] ALL = '1;

    // period, duty, expected high ticks per period
    localparam int ROWS = 10;
    localparam int TBL [ROWS][3] = '{
        '{10, 50, 5}, '{7, 33, 2}, '{3, 100, 3}, '{5, 0, 0}, '{1, 50, 0},
        '{1, 100, 1}, '{4, 120, 4}, '{9, 99, 8}, '{100, 1, 1}, '{6, 17, 1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [N-1:0]  pin_is_out = ALL;
    logic          cfg_valid = 1'b0;
    logic [N-1:0]  cfg_mask = '0;
    logic [PW-1:0] cfg_period = '0;
    logic [DW-1:0] cfg_duty = '0;
    logic          stop_valid = 1'b0;
    logic [N-1:0]  stop_mask = '0;
    logic [N-1:0]  blink_data;
    logic [N-1:0]  blink_own;
    logic          cfg_err;

    int checks = 0;
    int fails  = 0;
    int m_per [N];
    int m_thr [N];
    int m_cnt [N];
    logic [N-1:0] m_data = '0;
    logic [N-1:0] m_own  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blink_bank #(.NUM_PINS(N), .PERIOD_W(PW), .DUTY_W(DW)) i_blink_bank (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pin_is_out(pin_is_out),
        .cfg_valid(cfg_valid), .cfg_mask(cfg_mask), .cfg_period(cfg_period),
        .cfg_duty(cfg_duty), .stop_valid(stop_valid), .stop_mask(stop_mask),
        .blink_data(blink_data), .blink_own(blink_own), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %05h expected %05h", req, what, act, exp);
        end
    endtask

    // Model of the slots, written from the requirements.
    task automatic model_tick();
        for (int p = 0; p < N; p++) begin
            if (m_per[p] != 0) begin
                m_cnt[p] = m_cnt[p] + 1;
                if (m_cnt[p] >= m_per[p]) m_cnt[p] = 0;
                m_data[p] = (m_cnt[p] < m_thr[p]);
            end
        end
    endtask

    task automatic model_clear(input logic [N-1:0] mask);
        for (int p = 0; p < N; p++) begin
            if (mask[p]) begin
                m_per[p] = 0; m_thr[p] = 0; m_cnt[p] = 0;
                m_data[p] = 1'b0; m_own[p] = 1'b0;
            end
        end
    endtask

    task automatic model_cfg(input logic [N-1:0] mask, input int per, input int duty);
        int d;
        d = (duty > 100) ? 100 : duty;
        if (per == 0) begin
            model_clear(mask);
        end else begin
            for (int p = 0; p < N; p++) begin
                if (mask[p]) begin
                    m_per[p] = per; m_thr[p] = (per * d) / 100; m_cnt[p] = 0;
                    m_data[p] = 1'b0; m_own[p] = 1'b1;
                end
            end
        end
    endtask

    // One cycle of stimulus, model update, and output comparison.
    task automatic cycle(input string req, input logic tk,
                         input logic cv, input logic [N-1:0] cm, input int cp, input int cd,
                         input logic sv, input logic [N-1:0] sm);
        logic refuse;
        refuse = cv && ((cm & ~pin_is_out) != '0);
        @(negedge clk);
        tick = tk; cfg_valid = cv; cfg_mask = cm; cfg_period = PW'(cp);
        cfg_duty = DW'(cd); stop_valid = sv; stop_mask = sm;
        @(negedge clk);
        tick = 1'b0; cfg_valid = 1'b0; stop_valid = 1'b0;
        if (tk) model_tick();
        if (cv && !refuse) model_cfg(cm, cp, cd);
        if (sv) model_clear(sm);
        check(req, "data", blink_data, m_data);
        check(req, "own", blink_own, m_own);
        check(req, "err", N'(cfg_err), N'(refuse));
    endtask

    task automatic ticks(input string req, input int n);
        for (int i = 0; i < n; i++) cycle(req, 1'b1, 1'b0, '0, 0, 0, 1'b0, '0);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int p = 0; p < N; p++) begin m_per[p] = 0; m_thr[p] = 0; m_cnt[p] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "data", blink_data, '0);
        check("R1", "own", blink_own, '0);
        check("R1", "err", N'(cfg_err), '0);

        // R4 R5: table of rows, each on its own pin, one full period counted
        for (int r = 0; r < ROWS; r++) begin
            int highs;
            cycle("R7", 1'b0, 1'b0, '0, 0, 0, 1'b1, ALL);
            cycle("R2", 1'b0, 1'b1, N'(1) << r, TBL[r][0], TBL[r][1], 1'b0, '0);
            highs = 0;
            for (int k = 0; k < TBL[r][0]; k++) begin
                cycle("R4", 1'b1, 1'b0, '0, 0, 0, 1'b0, '0);
                if (blink_data[r]) highs++;
            end
            check("R4", "high ticks per period", N'(highs), N'(TBL[r][2]));
        end
        cycle("R7", 1'b0, 1'b0, '0, 0, 0, 1'b1, ALL);

        // R2 R10: two pin groups with different settings
        cycle("R2", 1'b0, 1'b1, 20'h00021, 4, 50, 1'b0, '0);
        ticks("R3", 2);
        cycle("R10", 1'b0, 1'b1, 20'h80002, 3, 34, 1'b0, '0);
        ticks("R10", 9);

        // R3: idle cycles with no tick leave outputs unchanged
        for (int i = 0; i < 4; i++) cycle("R3", 1'b0, 1'b0, '0, 0, 0, 1'b0, '0);

        // R7: stop pin 5 only, pin 0 keeps running
        cycle("R7", 1'b0, 1'b0, '0, 0, 0, 1'b1, 20'h00020);
        ticks("R7", 3);

        // R6: period zero acts as stop
        cycle("R6", 1'b0, 1'b1, 20'h00001, 0, 50, 1'b0, '0);
        ticks("R6", 2);

        // R8: pin 7 not an output, whole command refused
        pin_is_out = ALL & ~(N'(1) << 7);
        cycle("R8", 1'b0, 1'b1, 20'h00084, 5, 60, 1'b0, '0);
        check("R8", "own after refusal", blink_own & 20'h00084, '0);
        cycle("R8", 1'b0, 1'b0, '0, 0, 0, 1'b0, '0);
        pin_is_out = ALL;

        // R9: overlapping stop and configuration
        cycle("R9", 1'b0, 1'b1, 20'h00018, 2, 50, 1'b1, 20'h00011);
        check("R9", "pin 3 own, 4 stopped", blink_own & 20'h00018, 20'h00008);
        ticks("R9", 3);

        // R11: configuration arriving with a tick
        cycle("R11", 1'b1, 1'b1, 20'h00002, 5, 40, 1'b0, '0);
        ticks("R11", 6);

        // R5: duty above full scale is always high
        cycle("R5", 1'b0, 1'b1, 20'h00400, 3, 127, 1'b0, '0);
        ticks("R5", 3);
        check("R5", "pin 10 high", blink_data & 20'h00400, 20'h00400);

        finish_run();
    end
endmodule